// File: doc/BRIEF.md
# BCD clock-calendar counter

This block keeps wall-clock time and calendar date in packed binary-coded decimal. It counts seconds, minutes and hours in either a 12-hour format with an afternoon flag or a 24-hour format. It also counts the day of the month, the month, a two-digit year and a day-of-week counter. Month lengths, including February in leap years, are applied by the block itself.

A clock-enable input pulsing at 32768 Hz is divided down to a one-second advance. Eight byte-wide registers are presented on a combinational read port selected by an index. A write strobe with an index and a data byte loads one register at a time. A serial host interface in front of the block uses these two ports. A halt bit in the seconds register stops all counting until it is cleared.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read: index 0 = 0x80 (halted, 00 s), index 1 = 0x00, index 2 = 0x00 (24-hour, 00 h), index 3 = 0x01, index 4 = 0x01, index 5 = 0x01, index 6 = 0x00, index 7 = 0x00.
- R2: Time advances by one second once every REF_DIV cycles in which ref_en_i is high. A write to index 0 restarts that count from zero. A write to any other index leaves the count alone.
- R3: While bit 7 of the seconds register (index 0) is 1, no time or date register changes on a second boundary. After that bit is written to 0, counting resumes.
- R4: Seconds (index 0, bits 6:0) and minutes (index 1) count 00 to 59 in BCD, with the tens digit in bits 6:4. A step past 59 gives 00 and carries one into the next field.
- R5: With hours bit 7 = 0 (24-hour mode), hours count 00 to 23, with the tens digit in bits 5:4. A step past 23 gives 00 and carries one day into the date.
- R6: With hours bit 7 = 1 (12-hour mode), hours count 01 to 12 in bits 4:0, and bit 5 is the PM flag. 11 steps to 12 and inverts the flag. 12 steps to 01 and keeps the flag. 11 PM stepping to 12 AM carries one day into the date.
- R7: The date (index 3) wraps to 01 and advances the month (index 4) after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R8: In month 02 the date wraps after 29 when the year (index 6) is a multiple of 4 (00 counts as one), and after 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: The day of week (index 5) advances on every date carry, counting 1 to 7 and then back to 1, regardless of the date value.
- R11: Writes keep only the defined bits: masks 0xFF, 0x7F, 0xBF, 0x3F, 0x1F, 0x07 and 0xFF for indices 0 to 6. Unused bits read 0. Out-of-range BCD values within the mask are stored unchanged. Index 7 ignores writes and always reads 0x00.
- R12: rd_data_o shows the register selected by rd_idx_i in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | 32768 Hz timebase enable, one cycle high per reference period |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Register index for the write |
| wr_data_i | input | 8 | Write data byte |
| rd_idx_i | input | 3 | Register index for the read |
| rd_data_o | output | 8 | Selected register contents |

## Verification
The bench loads each register set just short of a rollover and then applies one second. Its cases include end of minute, end of hour, 23:59:59, the 11 and 12 o'clock transitions in 12-hour mode, 30- and 31-day months, February in leap and common years, year 99 and day-of-week 7.
- A design with the wrong month table or leap rule would leave a date of 29, 30 or 31 where a wrap was due, or wrap too early.
- A 12-hour mistake would either flip the PM flag at 12 to 01, or roll 11 PM over without advancing the date.

The divider is timed to the exact cycle, both after a seconds write and after a write to another index. A design that restarted the divider on every write, or never restarted it, would advance one second too early or too late. The write masks and halt bit are checked through the read port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_NUM = 8;
  localparam int unsigned IDX_W   = $clog2(REG_NUM);

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC  = 3'd0,
    IDX_MIN  = 3'd1,
    IDX_HOUR = 3'd2,
    IDX_DATE = 3'd3,
    IDX_MON  = 3'd4,
    IDX_DOW  = 3'd5,
    IDX_YEAR = 3'd6,
    IDX_RSVD = 3'd7
  } reg_idx_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 = 2 mod 4, so the year is divisible by 4 iff ones + 2*tens[0] is
  function automatic logic is_leap(input logic [7:0] yr);
    logic [3:0] s;
    s = yr[3:0] + {2'b00, yr[4], 1'b0};
    is_leap = (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      month_last = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    reg_mask = 8'hFF;
      3'd1:    reg_mask = 8'h7F;
      3'd2:    reg_mask = 8'hBF;
      3'd3:    reg_mask = 8'h3F;
      3'd4:    reg_mask = 8'h1F;
      3'd5:    reg_mask = 8'h07;
      3'd6:    reg_mask = 8'hFF;
      default: reg_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (ref_en_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !tick_o); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_TICK_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_i && !clr_i && cnt_q != LAST) |=> !tick_o); // R2
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic             day_carry_o
);
  logic [7:0] sec_q, min_q, hour_q, hour_n;
  logic       adv, sec_wrap, min_wrap, min_carry, hr_carry, day_c;
  logic       wr_sec, wr_min, wr_hour;

  assign wr_sec  = wr_en_i && (wr_idx_i == IDX_SEC);
  assign wr_min  = wr_en_i && (wr_idx_i == IDX_MIN);
  assign wr_hour = wr_en_i && (wr_idx_i == IDX_HOUR);

  assign adv       = tick_i && !sec_q[7];
  assign sec_wrap  = (sec_q[6:0] == 7'h59);
  assign min_wrap  = (min_q == 8'h59);
  assign min_carry = adv && sec_wrap;
  assign hr_carry  = min_carry && min_wrap;

  always_comb begin
    hour_n = hour_q;
    day_c  = 1'b0;
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h12) begin
        hour_n = {hour_q[7], 1'b0, hour_q[5], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_n = {hour_q[7], 1'b0, ~hour_q[5], 5'h12};
        day_c  = hour_q[5];
      end else if (hour_q[3:0] == 4'h9) begin
        hour_n = {hour_q[7:5], 1'b1, 4'h0};
      end else begin
        hour_n = {hour_q[7:4], hour_q[3:0] + 4'd1};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_n = 8'h00;
        day_c  = 1'b1;
      end else if (hour_q[3:0] == 4'h9) begin
        hour_n = {2'b00, hour_q[5:4] + 2'd1, 4'h0};
      end else begin
        hour_n = {hour_q[7:4], hour_q[3:0] + 4'd1};
      end
    end
  end

  assign day_carry_o = hr_carry && day_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h80;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec)         sec_q  <= wr_data_i;
      else if (adv)       sec_q  <= sec_wrap ? 8'h00 : bcd_inc({1'b0, sec_q[6:0]});
      if (wr_min)         min_q  <= wr_data_i;
      else if (min_carry) min_q  <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (wr_hour)        hour_q <= wr_data_i;
      else if (hr_carry)  hour_q <= hour_n;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q[7] && !wr_en_i) |=> $stable(sec_q) && $stable(min_q) && $stable(hour_q)); // R3
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && sec_wrap && !wr_en_i) |=> (sec_q == 8'h00)); // R4
  AST_24H_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry_o && !hour_q[7] && !wr_en_i) |=> (hour_q == 8'h00)); // R5
  AST_12H_NOON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_carry && hour_q[7] && hour_q[4:0] == 5'h11 && !wr_en_i)
      |=> (hour_q[4:0] == 5'h12) && (hour_q[5] != $past(hour_q[5]))); // R6
  AST_12H_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_carry && hour_q[7] && hour_q[4:0] == 5'h12 && !wr_en_i)
      |=> (hour_q[4:0] == 5'h01) && $stable(hour_q[5])); // R6
endmodule

// File: rtl/rtc_date_regs.sv
module rtc_date_regs
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             day_carry_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       date_o,
  output logic [7:0]       mon_o,
  output logic [7:0]       dow_o,
  output logic [7:0]       year_o
);
  logic [7:0] date_q, mon_q, dow_q, year_q, last_day;
  logic       date_wrap, mon_carry, year_carry;
  logic       wr_date, wr_mon, wr_dow, wr_year;

  assign wr_date = wr_en_i && (wr_idx_i == IDX_DATE);
  assign wr_mon  = wr_en_i && (wr_idx_i == IDX_MON);
  assign wr_dow  = wr_en_i && (wr_idx_i == IDX_DOW);
  assign wr_year = wr_en_i && (wr_idx_i == IDX_YEAR);

  assign last_day   = month_last(mon_q, is_leap(year_q));
  assign date_wrap  = (date_q == last_day);
  assign mon_carry  = day_carry_i && date_wrap;
  assign year_carry = mon_carry && (mon_q == 8'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_date)          date_q <= wr_data_i;
      else if (day_carry_i) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
      if (wr_mon)           mon_q  <= wr_data_i;
      else if (mon_carry)   mon_q  <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
      if (wr_dow)           dow_q  <= wr_data_i;
      else if (day_carry_i) dow_q  <= (dow_q == 8'h07) ? 8'h01 : dow_q + 8'd1;
      if (wr_year)          year_q <= wr_data_i;
      else if (year_carry)  year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign date_o = date_q;
  assign mon_o  = mon_q;
  assign dow_o  = dow_q;
  assign year_o = year_q;

  AST_FEB_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry_i && mon_q == 8'h02 && date_q == 8'h28 && !wr_en_i)
      |=> ((date_q == 8'h29) == is_leap(year_q))); // R8
  AST_SHORT_MONTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry_i && mon_q == 8'h04 && date_q == 8'h30 && !wr_en_i)
      |=> (date_q == 8'h01) && (mon_q == 8'h05)); // R7
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (year_carry && year_q == 8'h99 && !wr_en_i) |=> (year_q == 8'h00) && (mon_q == 8'h01)); // R9
  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_carry_i && dow_q == 8'h07 && !wr_en_i) |=> (dow_q == 8'h01)); // R10
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned REF_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_en_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_idx_i,
  output logic [7:0] rd_data_o
);
  logic       tick, day_carry, div_clr;
  logic [7:0] wr_data_m;
  logic [7:0] sec, min, hour, date, mon, dow, year;

  assign wr_data_m = wr_data_i & reg_mask(wr_idx_i);
  assign div_clr   = wr_en_i && (wr_idx_i == IDX_SEC);

  rtc_tick_div #(.DIV(REF_DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_en_i (ref_en_i),
    .clr_i    (div_clr),
    .tick_o   (tick)
  );

  rtc_time_regs u_time (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_m),
    .sec_o       (sec),
    .min_o       (min),
    .hour_o      (hour),
    .day_carry_o (day_carry)
  );

  rtc_date_regs u_date (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .day_carry_i (day_carry),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_m),
    .date_o      (date),
    .mon_o       (mon),
    .dow_o       (dow),
    .year_o      (year)
  );

  always_comb begin
    case (rd_idx_i)
      IDX_SEC:  rd_data_o = sec;
      IDX_MIN:  rd_data_o = min;
      IDX_HOUR: rd_data_o = hour;
      IDX_DATE: rd_data_o = date;
      IDX_MON:  rd_data_o = mon;
      IDX_DOW:  rd_data_o = dow;
      IDX_YEAR: rd_data_o = year;
      default:  rd_data_o = 8'h00;
    endcase
  end

  AST_UNUSED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min[7] == 1'b0) && (hour[6] == 1'b0) && (date[7:6] == 2'b00)
      && (mon[7:5] == 3'b000) && (dow[7:3] == 5'b00000)); // R11
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int NVEC       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_idx = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  bcd_calendar #(.REF_DIV(DIV)) u_bcd_calendar (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_en_i  (ref_en),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {sec,min,hour,date,mon,dow,year} before, then after one second
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h05_00_00_01_01_01_00, 56'h06_00_00_01_01_01_00},  // R4
    {56'h59_12_03_07_06_02_25, 56'h00_13_03_07_06_02_25},  // R4
    {56'h59_59_09_07_06_02_25, 56'h00_00_10_07_06_02_25},  // R4
    {56'h59_59_23_15_03_03_25, 56'h00_00_00_16_03_04_25},  // R5
    {56'h59_59_19_15_03_03_25, 56'h00_00_20_15_03_03_25},  // R5
    {56'h59_59_91_15_03_03_25, 56'h00_00_B2_15_03_03_25},  // R6 11 AM -> 12 PM
    {56'h59_59_B2_15_03_03_25, 56'h00_00_A1_15_03_03_25},  // R6 12 PM -> 1 PM
    {56'h59_59_B1_10_03_07_25, 56'h00_00_92_11_03_01_25},  // R6 R10
    {56'h59_59_23_30_04_02_25, 56'h00_00_00_01_05_03_25},  // R7
    {56'h59_59_23_30_03_02_25, 56'h00_00_00_31_03_03_25},  // R7
    {56'h59_59_23_28_02_05_24, 56'h00_00_00_29_02_06_24},  // R8
    {56'h59_59_23_28_02_05_23, 56'h00_00_00_01_03_06_23},  // R8
    {56'h59_59_23_29_02_05_12, 56'h00_00_00_01_03_06_12},  // R8
    {56'h59_59_23_28_02_05_00, 56'h00_00_00_29_02_06_00},  // R8
    {56'h59_59_23_31_12_07_99, 56'h00_00_00_01_01_01_00},  // R9
    {56'h59_59_A9_05_08_01_40, 56'h00_00_B0_05_08_01_40}   // R6 9 PM -> 10 PM
  };
  localparam int VTAG [NVEC] = '{4,4,4,5,5,6,6,6,7,7,8,8,8,8,9,6};

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] data);
    rd_idx = idx;
    #1;
    data = rd_data;
  endtask

  task automatic one_second();
    @(negedge clk);
    ref_en = 1'b1;
    repeat (DIV + 1) @(negedge clk);
    ref_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_rst [8];
    exp_rst = '{8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1 reset", v, exp_rst[i]);
    end

    // Vector table: load registers, seconds last so the divider starts clean
    for (int n = 0; n < NVEC; n++) begin
      logic [55:0] vin, vout;
      vin  = VEC[n][111:56];
      vout = VEC[n][55:0];
      for (int k = 1; k < 7; k++) wr(3'(k), vin[55-8*k -: 8]);
      wr(3'd0, vin[55:48]);
      one_second();
      for (int k = 0; k < 7; k++) begin
        rd(3'(k), v);
        check($sformatf("R%0d vector %0d idx %0d", VTAG[n], n, k), v, vout[55-8*k -: 8]);
      end
    end

    // R2 exact spacing after a seconds write
    wr(3'd0, 8'h10);
    @(negedge clk); ref_en = 1'b1;
    repeat (5) @(negedge clk);
    ref_en = 1'b0;
    wr(3'd0, 8'h20);
    ref_en = 1'b1;
    repeat (DIV) @(negedge clk);
    rd(3'd0, v); check("R2 no advance before DIV enables", v, 8'h20);
    @(negedge clk);
    rd(3'd0, v); check("R2 advance after DIV enables", v, 8'h21);
    ref_en = 1'b0;

    // R2 a minutes write keeps the divider count
    wr(3'd0, 8'h30);
    @(negedge clk); ref_en = 1'b1;
    repeat (5) @(negedge clk);
    ref_en = 1'b0;
    wr(3'd1, 8'h07);
    ref_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R2 minutes write no restart, before", v, 8'h30);
    @(negedge clk);
    rd(3'd0, v); check("R2 minutes write no restart, after", v, 8'h31);
    ref_en = 1'b0;

    // R3 halt bit freezes counting
    wr(3'd1, 8'h59);
    wr(3'd0, 8'hD9);
    one_second();
    rd(3'd0, v); check("R3 halted seconds", v, 8'hD9);
    rd(3'd1, v); check("R3 halted minutes", v, 8'h59);
    one_second();
    rd(3'd0, v); check("R3 still halted", v, 8'hD9);
    wr(3'd0, 8'h58);
    one_second();
    rd(3'd0, v); check("R3 resumed seconds", v, 8'h59);

    // R11 masks, out-of-range storage, reserved index
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R11 minutes mask", v, 8'h7F);
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R11 hours mask", v, 8'hBF);
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R11 date mask", v, 8'h3F);
    wr(3'd4, 8'hFF); rd(3'd4, v); check("R11 month mask", v, 8'h1F);
    wr(3'd5, 8'hFF); rd(3'd5, v); check("R11 dow mask", v, 8'h07);
    wr(3'd6, 8'hFF); rd(3'd6, v); check("R11 year out of range kept", v, 8'hFF);
    wr(3'd1, 8'h75); rd(3'd1, v); check("R11 minutes out of range kept", v, 8'h75);
    wr(3'd7, 8'hFF); rd(3'd7, v); check("R11 reserved index reads zero", v, 8'h00);
    rd(3'd0, v); check("R11 reserved write leaves seconds", v, 8'h59);

    // R12 read port is combinational: switch index mid-cycle
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd4, v); check("R12 same-cycle read idx 4", v, 8'h1F);
    rd(3'd1, v); check("R12 same-cycle read idx 1", v, 8'h75);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule